// File: doc/BRIEF.md
# Multi-Vector Accumulator Row Sequencer

This block sits between instruction decode and the accumulator-array datapath for a multi-vector subtract-into-accumulator operation. It accepts one decoded request, checks that the request is legal for the enabled features, and then issues a short burst of (accumulator row, source vector register) pairs, one pair per clock. The floating-point arithmetic and the register storage sit downstream. This block only produces addresses and the legality verdict.

A request covers a group of two or four source registers. The accumulator array has one row per byte of vector length. It is split into equal slices, one slice per group member. The starting row is the sum of a base register value and a small offset, reduced modulo the slice size. Each following pair moves exactly one slice further down the array, so every group member lands in its own half or quarter. The element size and the number of elements per row are held beside each pair so that the datapath can walk every element of the row. The operation has no predicate, so every element is written.

Top module: `mvacc_row_seq`

## Requirements
- R1: A request on `req_valid` is taken only while the block is idle: no pair is being issued and `seq_done` is not showing. A request presented at any other time has no effect on the outputs. After every `seq_done` cycle there is at least one cycle with neither `pair_valid` nor `seq_done`. `req_vl_log2` (log2 of the vector length in bits) lies in 7..11.
- R2: `base_reg` shows the base general-purpose register number `{3'b010, req_sel}` (8 to 11). It holds from the first pair through `seq_done`.
- R3: `elem_bits` is 16 when `req_half` is 1, and `req_size` is then ignored. Otherwise it is 32 when `req_size` is 0 and 64 when `req_size` is 1.
- R4: `elem_count` equals the vector length in bits divided by `elem_bits`.
- R5: The first source register is `{req_zm, 1'b0}` for a group of two (`req_quad`=0) and `{req_zm[2:0], 2'b00}` for a group of four (`req_quad`=1). Pair r uses the first register plus r.
- R6: With the row count equal to the vector length divided by 8, and the stride equal to the row count divided by the group size, the first row is (32-bit `req_base` + `req_off`) modulo the stride.
- R7: A legal request yields exactly 2 or 4 pairs on consecutive cycles. The first comes the cycle after acceptance, and each row is the previous row plus the stride.
- R8: `seq_done` is a single-cycle pulse in the cycle after the last pair, with `enc_undef` low for a legal request.
- R9: With `req_half`=0, the request is undefined when `en_multivec` is 0, or when `req_size` is 1 and `en_fp64` is 0.
- R10: With `req_half`=1, the request is undefined only when both `en_fp16` and `en_fp16_alt` are 0.
- R11: An undefined request issues no pair. `seq_done` and `enc_undef` are both high in the cycle after acceptance.
- R12: After reset, `pair_valid`, `seq_done` and `enc_undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_half | input | 1 | Half-precision form of the operation |
| req_size | input | 1 | Element size select (0: 32, 1: 64) |
| req_sel | input | 2 | Base register selector |
| req_base | input | 32 | Value of the base register |
| req_off | input | 3 | Row offset |
| req_zm | input | 4 | Source register field |
| req_quad | input | 1 | 0: group of two, 1: group of four |
| req_vl_log2 | input | 4 | log2 of vector length in bits (7..11) |
| en_multivec | input | 1 | Multi-vector feature enabled |
| en_fp64 | input | 1 | Double-precision form enabled |
| en_fp16 | input | 1 | First half-precision enable |
| en_fp16_alt | input | 1 | Second half-precision enable |
| pair_valid | output | 1 | Row/register pair valid |
| pair_row | output | 8 | Accumulator row index |
| pair_src | output | 5 | Source vector register index |
| elem_bits | output | 7 | Element size in bits |
| elem_count | output | 8 | Elements per row |
| base_reg | output | 5 | Base register number |
| seq_done | output | 1 | Sequence finished pulse |
| enc_undef | output | 1 | Request is undefined (valid with seq_done) |

## Verification
The assertions assume that every accepted request carries a vector length from 128 to 2048 bits. The stride arithmetic treats the row count as a power of two of at least 16, and the row-step and row-index checks rely on that. The bench draws `req_vl_log2` only from 7..11. It also keeps the request fields steady while `req_valid` is being sampled in the idle state, so that the only requests arriving mid-sequence are the deliberate ones, and their fields change every cycle.

// File: rtl/mvacc_pkg.sv
package mvacc_pkg;

  localparam int SRC_W = 5;
  localparam int EB_W  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  function automatic logic [EB_W-1:0] f_elem_bits(input logic half, input logic size);
    if (half) return EB_W'(16);
    return size ? EB_W'(64) : EB_W'(32);
  endfunction

  function automatic logic [3:0] f_elem_log2(input logic half, input logic size);
    if (half) return 4'd4;
    return size ? 4'd6 : 4'd5;
  endfunction

  function automatic logic [SRC_W-1:0] f_first_src(input logic [3:0] zm, input logic quad);
    return quad ? {zm[2:0], 2'b00} : {zm, 1'b0};
  endfunction

  function automatic logic [SRC_W-1:0] f_base_reg(input logic [1:0] sel);
    return {3'b010, sel};
  endfunction

  function automatic logic f_undef(input logic half, input logic size,
                                   input logic en_mv, input logic en_64,
                                   input logic en_16, input logic en_16b);
    if (half) return !(en_16 || en_16b);
    return !en_mv || (size && !en_64);
  endfunction

endpackage

// File: rtl/mvacc_decode.sv
module mvacc_decode
  import mvacc_pkg::*;
#(
  parameter int MIN_VL_LOG2 = 7,
  parameter int MAX_VL_LOG2 = 11,
  parameter int BASE_W      = 32,
  parameter int ROW_W       = MAX_VL_LOG2 - 3,
  parameter int ECNT_W      = MAX_VL_LOG2 - 3
) (
  input  logic              half,
  input  logic              size,
  input  logic [1:0]        sel,
  input  logic [BASE_W-1:0] base,
  input  logic [2:0]        off,
  input  logic [3:0]        zm,
  input  logic              quad,
  input  logic [3:0]        vl_log2,
  input  logic              en_mv,
  input  logic              en_64,
  input  logic              en_16,
  input  logic              en_16b,
  output logic              undef,
  output logic [EB_W-1:0]   ebits,
  output logic [ECNT_W-1:0] ecnt,
  output logic [SRC_W-1:0]  first_src,
  output logic [SRC_W-1:0]  base_num,
  output logic [3:0]        stride_log2,
  output logic [ROW_W-1:0]  start_row,
  output logic              vl_ok
);

  logic [BASE_W-1:0] sum_full;
  logic [BASE_W-1:0] stride_mask;

  always_comb begin
    undef       = f_undef(half, size, en_mv, en_64, en_16, en_16b);
    ebits       = f_elem_bits(half, size);
    ecnt        = ECNT_W'(1) << (vl_log2 - f_elem_log2(half, size));
    first_src   = f_first_src(zm, quad);
    base_num    = f_base_reg(sel);
    // rows = 2^(vl-3); stride = rows / (2 or 4)
    stride_log2 = vl_log2 - 4'd3 - (quad ? 4'd2 : 4'd1);
    sum_full    = base + BASE_W'(off);
    stride_mask = (BASE_W'(1) << stride_log2) - BASE_W'(1);
    start_row   = ROW_W'(sum_full & stride_mask);
    vl_ok       = (vl_log2 >= 4'(MIN_VL_LOG2)) && (vl_log2 <= 4'(MAX_VL_LOG2));
  end

endmodule

// File: rtl/mvacc_seq_ctrl.sv
module mvacc_seq_ctrl
  import mvacc_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int ECNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              d_undef,
  input  logic [EB_W-1:0]   d_ebits,
  input  logic [ECNT_W-1:0] d_ecnt,
  input  logic [SRC_W-1:0]  d_first,
  input  logic [SRC_W-1:0]  d_base_num,
  input  logic [3:0]        d_stride_log2,
  input  logic [ROW_W-1:0]  d_start_row,
  input  logic              d_quad,
  input  logic              d_vl_ok,
  output logic              pair_valid,
  output logic [ROW_W-1:0]  pair_row,
  output logic [SRC_W-1:0]  pair_src,
  output logic [EB_W-1:0]   elem_bits,
  output logic [ECNT_W-1:0] elem_count,
  output logic [SRC_W-1:0]  base_reg,
  output logic              seq_done,
  output logic              enc_undef
);

  seq_state_e        state;
  logic [1:0]        idx;
  logic [ROW_W-1:0]  row_q;
  logic [SRC_W-1:0]  first_q;
  logic [3:0]        stride_q;
  logic              quad_q;
  logic              undef_q;
  logic [EB_W-1:0]   eb_q;
  logic [ECNT_W-1:0] ec_q;
  logic [SRC_W-1:0]  br_q;

  // named events for the assertions
  logic             accept;
  logic             last_pair;
  logic [ROW_W-1:0] stride_val;

  assign accept     = req_valid && (state == ST_IDLE);
  assign last_pair  = (state == ST_ISSUE) && (idx == (quad_q ? 2'd3 : 2'd1));
  assign stride_val = ROW_W'(1) << stride_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      row_q    <= '0;
      first_q  <= '0;
      stride_q <= '0;
      quad_q   <= 1'b0;
      undef_q  <= 1'b0;
      eb_q     <= '0;
      ec_q     <= '0;
      br_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            idx      <= '0;
            row_q    <= d_start_row;
            first_q  <= d_first;
            stride_q <= d_stride_log2;
            quad_q   <= d_quad;
            undef_q  <= d_undef;
            eb_q     <= d_ebits;
            ec_q     <= d_ecnt;
            br_q     <= d_base_num;
            state    <= d_undef ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (last_pair) begin
            state <= ST_DONE;
          end else begin
            idx   <= idx + 2'd1;
            row_q <= row_q + stride_val;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pair_valid = (state == ST_ISSUE);
  assign pair_row   = row_q;
  assign pair_src   = first_q + SRC_W'(idx);
  assign elem_bits  = eb_q;
  assign elem_count = ec_q;
  assign base_reg   = br_q;
  assign seq_done   = (state == ST_DONE);
  assign enc_undef  = seq_done && undef_q;

  // R1: accepted requests carry a supported vector length
  a_r1_vl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> d_vl_ok);

  // R1: an idle gap always follows completion
  a_r1_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !pair_valid && !seq_done);

  // R5: first register of a burst is aligned to the group size
  a_r5_src_align: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !$past(pair_valid) |-> (pair_src[0] == 1'b0) && (!quad_q || pair_src[1:0] == 2'b00));

  // R6: a row divided by the stride gives the member index
  a_r6_row_slice: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (pair_row >> stride_q) == ROW_W'(idx));

  // R7: consecutive pairs step by one stride
  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && $past(pair_valid) |-> (pair_row - $past(pair_row)) == stride_val);

  // R8: done follows the last pair and lasts one cycle
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_pair |=> seq_done && !enc_undef);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R11: undefined request finishes at once with no pairs
  a_r11_undef_fast: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_undef |=> seq_done && enc_undef && !pair_valid);

endmodule

// File: rtl/mvacc_row_seq.sv
module mvacc_row_seq
  import mvacc_pkg::*;
#(
  parameter int MIN_VL_LOG2 = 7,
  parameter int MAX_VL_LOG2 = 11,
  parameter int BASE_W      = 32,
  localparam int ROW_W      = MAX_VL_LOG2 - 3,
  localparam int ECNT_W     = MAX_VL_LOG2 - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_half,
  input  logic              req_size,
  input  logic [1:0]        req_sel,
  input  logic [BASE_W-1:0] req_base,
  input  logic [2:0]        req_off,
  input  logic [3:0]        req_zm,
  input  logic              req_quad,
  input  logic [3:0]        req_vl_log2,
  input  logic              en_multivec,
  input  logic              en_fp64,
  input  logic              en_fp16,
  input  logic              en_fp16_alt,
  output logic              pair_valid,
  output logic [ROW_W-1:0]  pair_row,
  output logic [SRC_W-1:0]  pair_src,
  output logic [EB_W-1:0]   elem_bits,
  output logic [ECNT_W-1:0] elem_count,
  output logic [SRC_W-1:0]  base_reg,
  output logic              seq_done,
  output logic              enc_undef
);

  logic              d_undef;
  logic [EB_W-1:0]   d_ebits;
  logic [ECNT_W-1:0] d_ecnt;
  logic [SRC_W-1:0]  d_first;
  logic [SRC_W-1:0]  d_base_num;
  logic [3:0]        d_stride_log2;
  logic [ROW_W-1:0]  d_start_row;
  logic              d_vl_ok;

  mvacc_decode #(
    .MIN_VL_LOG2 (MIN_VL_LOG2),
    .MAX_VL_LOG2 (MAX_VL_LOG2),
    .BASE_W      (BASE_W),
    .ROW_W       (ROW_W),
    .ECNT_W      (ECNT_W)
  ) u_decode (
    .half        (req_half),
    .size        (req_size),
    .sel         (req_sel),
    .base        (req_base),
    .off         (req_off),
    .zm          (req_zm),
    .quad        (req_quad),
    .vl_log2     (req_vl_log2),
    .en_mv       (en_multivec),
    .en_64       (en_fp64),
    .en_16       (en_fp16),
    .en_16b      (en_fp16_alt),
    .undef       (d_undef),
    .ebits       (d_ebits),
    .ecnt        (d_ecnt),
    .first_src   (d_first),
    .base_num    (d_base_num),
    .stride_log2 (d_stride_log2),
    .start_row   (d_start_row),
    .vl_ok       (d_vl_ok)
  );

  mvacc_seq_ctrl #(
    .ROW_W  (ROW_W),
    .ECNT_W (ECNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .d_undef       (d_undef),
    .d_ebits       (d_ebits),
    .d_ecnt        (d_ecnt),
    .d_first       (d_first),
    .d_base_num    (d_base_num),
    .d_stride_log2 (d_stride_log2),
    .d_start_row   (d_start_row),
    .d_quad        (req_quad),
    .d_vl_ok       (d_vl_ok),
    .pair_valid    (pair_valid),
    .pair_row      (pair_row),
    .pair_src      (pair_src),
    .elem_bits     (elem_bits),
    .elem_count    (elem_count),
    .base_reg      (base_reg),
    .seq_done      (seq_done),
    .enc_undef     (enc_undef)
  );

  // R12: nothing is reported while reset is held
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !pair_valid && !seq_done && !enc_undef);

endmodule

// File: tb/test_mvacc_row_seq.sv
module test_mvacc_row_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_half = 1'b0;
  logic        req_size = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [31:0] req_base = '0;
  logic [2:0]  req_off = '0;
  logic [3:0]  req_zm = '0;
  logic        req_quad = 1'b0;
  logic [3:0]  req_vl_log2 = 4'd7;
  logic        en_multivec = 1'b1;
  logic        en_fp64 = 1'b1;
  logic        en_fp16 = 1'b1;
  logic        en_fp16_alt = 1'b1;
  logic        pair_valid;
  logic [7:0]  pair_row;
  logic [4:0]  pair_src;
  logic [6:0]  elem_bits;
  logic [7:0]  elem_count;
  logic [4:0]  base_reg;
  logic        seq_done;
  logic        enc_undef;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mvacc_row_seq i_mvacc_row_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_half(req_half),
    .req_size(req_size), .req_sel(req_sel), .req_base(req_base), .req_off(req_off),
    .req_zm(req_zm), .req_quad(req_quad), .req_vl_log2(req_vl_log2),
    .en_multivec(en_multivec), .en_fp64(en_fp64), .en_fp16(en_fp16),
    .en_fp16_alt(en_fp16_alt), .pair_valid(pair_valid), .pair_row(pair_row),
    .pair_src(pair_src), .elem_bits(elem_bits), .elem_count(elem_count),
    .base_reg(base_reg), .seq_done(seq_done), .enc_undef(enc_undef)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  function automatic bit m_undef(bit half, bit size, bit fm, bit f64, bit f16, bit f16b);
    if (half) return (f16 == 0) && (f16b == 0);
    if (fm == 0) return 1;
    return (size == 1) && (f64 == 0);
  endfunction

  function automatic int m_ebits(bit half, bit size);
    if (half) return 16;
    return (size == 1) ? 64 : 32;
  endfunction

  function automatic int m_first(bit [3:0] zm, bit quad);
    if (quad) return (zm % 8) * 4;
    return zm * 2;
  endfunction

  function automatic int m_stride(int vl_log2, bit quad);
    return ((1 << vl_log2) / 8) / (quad ? 4 : 2);
  endfunction

  function automatic int m_row(bit [31:0] base, bit [2:0] off, int vl_log2, bit quad, int r);
    longint s;
    int st;
    st = m_stride(vl_log2, quad);
    s  = (longint'(base) + longint'(off)) % st;
    return int'(s) + r * st;
  endfunction

  task automatic scramble_fields();
    req_half    = 1'($urandom);
    req_size    = 1'($urandom);
    req_sel     = 2'($urandom);
    req_base    = $urandom;
    req_off     = 3'($urandom);
    req_zm      = 4'($urandom);
    req_quad    = 1'($urandom);
    req_vl_log2 = 4'(7 + $urandom % 5);
  endtask

  task automatic run_req(input bit half, input bit size, input bit [1:0] sel,
                         input bit [31:0] base, input bit [2:0] off, input bit [3:0] zm,
                         input bit quad, input int vl, input bit fm, input bit f64,
                         input bit f16, input bit f16b, input bit hold_busy);
    bit ud;
    int n;
    @(negedge clk);
    req_half = half; req_size = size; req_sel = sel; req_base = base; req_off = off;
    req_zm = zm; req_quad = quad; req_vl_log2 = 4'(vl);
    en_multivec = fm; en_fp64 = f64; en_fp16 = f16; en_fp16_alt = f16b;
    req_valid = 1'b1;
    ud = m_undef(half, size, fm, f64, f16, f16b);
    n  = quad ? 4 : 2;
    @(negedge clk);
    if (ud) begin
      chk("R11 done after undefined request", seq_done, 1);
      chk("R9/R10 undefined flag", enc_undef, 1);
      chk("R11 no pair for undefined request", pair_valid, 0);
      if (hold_busy) scramble_fields(); else req_valid = 1'b0;
    end else begin
      for (int r = 0; r < n; r++) begin
        chk("R7 pair valid", pair_valid, 1);
        chk("R6 R7 pair row", pair_row, m_row(base, off, vl, quad, r));
        chk("R5 pair source", pair_src, m_first(zm, quad) + r);
        chk("R2 base register", base_reg, 8 + sel);
        chk("R3 element size", elem_bits, m_ebits(half, size));
        chk("R4 element count", elem_count, (1 << vl) / m_ebits(half, size));
        chk("R8 no done during pairs", seq_done, 0);
        if (hold_busy) scramble_fields(); else req_valid = 1'b0;
        @(negedge clk);
      end
      chk("R8 done after last pair", seq_done, 1);
      chk("R8 legal request not undefined", enc_undef, 0);
      chk("R7 no extra pair", pair_valid, 0);
      chk("R2 base register held at done", base_reg, 8 + sel);
      if (hold_busy) scramble_fields();
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 R8 idle after done", seq_done, 0);
    chk("R1 busy request ignored", pair_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 reset pair_valid", pair_valid, 0);
    chk("R12 reset seq_done", seq_done, 0);
    chk("R12 reset enc_undef", enc_undef, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    run_req(0, 0, 2'd0, 32'hFFFF_FFFF, 3'd7, 4'd3, 1, 7,  1, 1, 1, 1, 0); // R6 wrap of 32-bit sum
    run_req(0, 1, 2'd3, 32'd1000,      3'd5, 4'hF, 0, 11, 1, 1, 1, 1, 0); // largest stride
    run_req(0, 0, 2'd1, 32'd9,         3'd0, 4'hF, 1, 9,  1, 0, 0, 0, 1); // R5 zm[3] dropped
    run_req(1, 1, 2'd2, 32'd123,       3'd2, 4'd5, 0, 8,  0, 0, 1, 0, 0); // R3 size ignored, R10
    run_req(1, 0, 2'd2, 32'd7,         3'd1, 4'd2, 1, 10, 0, 0, 0, 1, 0); // R10 second enable alone
    run_req(1, 0, 2'd0, 32'd7,         3'd1, 4'd2, 1, 10, 1, 1, 0, 0, 0); // R10 undefined
    run_req(0, 0, 2'd0, 32'd7,         3'd1, 4'd2, 0, 10, 0, 1, 1, 1, 0); // R9 no multivec
    run_req(0, 1, 2'd0, 32'd7,         3'd1, 4'd2, 0, 10, 1, 0, 1, 1, 1); // R9 no fp64, busy
    run_req(0, 0, 2'd0, 32'd7,         3'd1, 4'd2, 0, 10, 1, 0, 1, 1, 1); // R9 32-bit legal w/o fp64

    // constrained random
    for (int i = 0; i < 400; i++) begin
      run_req(1'($urandom), 1'($urandom), 2'($urandom), $urandom, 3'($urandom),
              4'($urandom), 1'($urandom), 7 + int'($urandom % 5),
              ($urandom % 8) != 0, ($urandom % 3) != 0,
              ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 3) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule